// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block produces one digital sine sample and one cosine sample on every enabled clock. A 32-bit phase register advances by an unsigned tuning word each time the sample strobe is high and wraps silently past its full range. The output frequency is therefore the tuning word times the clock rate divided by 2^32. The tuning word is 31 bits wide, so the reachable band runs from DC up to just under half the clock rate.

A separate 16-bit offset word is added to the top of the running phase before the waveform stage. This lets a caller shift the phase without touching the frequency. Only the 14 upper bits of the offset phase reach the waveform generator, and the lower 18 bits are dropped. The generator covers one full period across those 14 bits. It evaluates only a quarter wave and rebuilds the other three quadrants by mirroring the index and flipping the sign. The cosine channel uses the same generator with its address advanced by a quarter cycle. Both channels leave the block as 16-bit signed values with a valid flag.

Top module: `quad_nco`

## Requirements
- R1: A synchronous reset clears outValid, sinOut and cosOut to zero and sets the phase register to zero, so the first sample after reset has the phase of the offset word alone.
- R2: Each clock with sampleEn high adds freqWord, zero-extended to 32 bits, to the phase register. Sample k after reset uses phase k*freqWord + phaseWord*2^16 modulo 2^32.
- R3: While sampleEn is low the phase register does not advance. outValid is low two clocks later, and sinOut and cosOut keep their previous values.
- R4: The phase register wraps modulo 2^32, so the waveform continues across the rollover with no jump, including at the largest tuning word 0x7FFFFFFF.
- R5: phaseWord is placed at bits 31:16 of the phase and added to the phase register output. A value of 0x4000 advances both outputs by a quarter cycle.
- R6: Only bits 31:18 of the offset phase, P, select the output. Phase changes confined to the lower 18 bits leave the outputs unchanged.
- R7: sinOut equals round(32767*sin(2*pi*P/16384)) within 2 LSB. It is exactly 0, 32767, 0 and -32767 at P = 0, 4096, 8192 and 12288, and it never reaches -32768.
- R8: cosOut equals the R7 sine value at address (P+4096) mod 16384.
- R9: A sample strobed on clock edge n appears on sinOut and cosOut after edge n+2, with outValid high for exactly that cycle.
- R10: A freqWord whose lower 18 bits are zero gives an exactly periodic output. With freqWord 0x10000000, every sample equals the one 16 samples later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Advance phase and produce a sample this clock |
| freqWord | input | 31 | Unsigned tuning word, phase step per sample |
| phaseWord | input | 16 | Phase offset, aligned to the top of the phase |
| sinOut | output | 16 | Signed sine sample |
| cosOut | output | 16 | Signed cosine sample |
| outValid | output | 1 | sinOut and cosOut carry a new sample |

## Verification
The hardest case to reach from the ports is the phase register crossing its 2^32 rollover while samples are still flowing. Small tuning words would need billions of clocks to get there. The bench therefore drives the largest legal tuning word, which wraps the register about every two samples, and also uses mid-size words that wrap within a few dozen samples. A reference model in the bench follows the phase modulo 2^32 and compares every output against a real-valued sine. Quadrant boundaries are reached exactly by holding the tuning word at zero and stepping the offset word through its four quarter points.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic stepAcc;    // advance phase register
    logic loadPhase;  // capture truncated offset phase
    logic loadOut;    // capture waveform samples
  } nco_strobe_t;

  // fixed-point fraction bits for the quarter-wave polynomial
  localparam int FRAC = 30;

  // odd series coefficients for sin(pi/2 * x), scaled by 2^30, magnitudes
  localparam logic signed [63:0] C1 = 64'sd1686629713;
  localparam logic signed [63:0] C3 = 64'sd693598668;
  localparam logic signed [63:0] C5 = 64'sd85569305;
  localparam logic signed [63:0] C7 = 64'sd5026995;
  localparam logic signed [63:0] C9 = 64'sd172272;

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleEn,
  output nco_strobe_t strobes,
  output logic        outValid
);

  logic tapValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      tapValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      tapValid <= sampleEn;
      outValid <= tapValid;
    end
  end

  always_comb begin
    strobes.stepAcc   = sampleEn;
    strobes.loadPhase = sampleEn;
    strobes.loadOut   = tapValid;
  end

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int FCW_W = 31,
  parameter int PCW_W = 16,
  parameter int LUT_W = 14,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  nco_strobe_t             strobes,
  input  logic [FCW_W-1:0]        freqWord,
  input  logic [PCW_W-1:0]        phaseWord,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut
);

  localparam int IDX_W   = LUT_W - 2;
  localparam int QUARTER = 1 << IDX_W;
  localparam int CHANNELS = 2;
  localparam logic signed [63:0] AMP = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] offsetPhase;
  logic [LUT_W-1:0] phaseTap;
  logic signed [OUT_W-1:0] nextWave [CHANNELS];

  assign offsetPhase = acc + {phaseWord, {(ACC_W - PCW_W){1'b0}}};

  // quarter-wave magnitude for index 0..QUARTER (inclusive)
  function automatic logic [OUT_W-1:0] quarterSine(input logic [IDX_W:0] idx);
    logic signed [63:0] x, x2, t, y;
    x  = $signed(64'(idx)) <<< (FRAC - IDX_W);
    x2 = (x * x) >>> FRAC;
    t  = C9;
    t  = C7 - ((t * x2) >>> FRAC);
    t  = C5 - ((t * x2) >>> FRAC);
    t  = C3 - ((t * x2) >>> FRAC);
    t  = C1 - ((t * x2) >>> FRAC);
    t  = (t * x) >>> FRAC;
    y  = (t * AMP + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (y > AMP) y = AMP;
    if (y < 0)   y = 64'sd0;
    return y[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      phaseTap <= '0;
    end else begin
      if (strobes.stepAcc)
        acc <= acc + {{(ACC_W - FCW_W){1'b0}}, freqWord};
      if (strobes.loadPhase)
        phaseTap <= offsetPhase[ACC_W-1 -: LUT_W];
    end
  end

  // channel 0 is sine, channel 1 is cosine (quarter-cycle advanced)
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [LUT_W-1:0] addr;
    logic [IDX_W:0]   foldIdx;
    logic [OUT_W-1:0] mag;
    assign addr    = phaseTap + LUT_W'(ch * QUARTER);
    assign foldIdx = addr[LUT_W-2] ? ((IDX_W + 1)'(QUARTER) - {1'b0, addr[IDX_W-1:0]})
                                   : {1'b0, addr[IDX_W-1:0]};
    assign mag     = quarterSine(foldIdx);
    assign nextWave[ch] = addr[LUT_W-1] ? -$signed(mag) : $signed(mag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sinOut <= '0;
      cosOut <= '0;
    end else if (strobes.loadOut) begin
      sinOut <= nextWave[0];
      cosOut <= nextWave[1];
    end
  end

endmodule

// File: rtl/quad_nco.sv
module quad_nco
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int FCW_W = 31,
  parameter int PCW_W = 16,
  parameter int LUT_W = 14,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleEn,
  input  logic [FCW_W-1:0]        freqWord,
  input  logic [PCW_W-1:0]        phaseWord,
  output logic signed [OUT_W-1:0] sinOut,
  output logic signed [OUT_W-1:0] cosOut,
  output logic                    outValid
);

  nco_strobe_t strobes;

  nco_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sampleEn (sampleEn),
    .strobes  (strobes),
    .outValid (outValid)
  );

  nco_datapath #(
    .ACC_W (ACC_W),
    .FCW_W (FCW_W),
    .PCW_W (PCW_W),
    .LUT_W (LUT_W),
    .OUT_W (OUT_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .freqWord  (freqWord),
    .phaseWord (phaseWord),
    .sinOut    (sinOut),
    .cosOut    (cosOut)
  );

endmodule

// File: rtl/quad_nco_chk.sv
module quad_nco_chk #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sampleEn,
  input logic signed [OUT_W-1:0] sinOut,
  input logic signed [OUT_W-1:0] cosOut,
  input logic                    outValid
);

  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && sinOut == '0 && cosOut == '0));

  // R9
  sample_latency_chk: assert property (@(posedge clk) disable iff (rst)
    sampleEn |-> ##2 outValid);

  // R3
  idle_novalid_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |-> ##2 !outValid);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> ($stable(sinOut) && $stable(cosOut)));

  // R7
  symmetric_range_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sinOut != MOST_NEG && cosOut != MOST_NEG));

endmodule

bind quad_nco quad_nco_chk #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sampleEn (sampleEn),
  .sinOut   (sinOut),
  .cosOut   (cosOut),
  .outValid (outValid)
);

// File: tb/quad_nco_test.sv
module quad_nco_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [30:0] fcw = '0;
  logic [15:0] pcw = '0;
  logic signed [15:0] sinOut, cosOut;
  logic        outValid;

  quad_nco uut (
    .clk(clk), .rst(rst), .sampleEn(en), .freqWord(fcw), .phaseWord(pcw),
    .sinOut(sinOut), .cosOut(cosOut), .outValid(outValid)
  );

  always #2 clk = ~clk;  // 250 MHz

  int    vecs = 0;
  int    errs = 0;
  bit    done = 0;
  string curReq = "R1";

  // reference model state
  logic [31:0] accM = '0;
  bit          expV1 = 0, expV2 = 0;
  logic [13:0] expP1 = '0, expP2 = '0;
  int          heldSin = 0, heldCos = 0;

  function automatic int refWave(logic [13:0] p, int ch);
    real a, v;
    a = 2.0 * 3.14159265358979 * (real'(p) + ch * 4096.0) / 16384.0;
    v = 32767.0 * $sin(a);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic chk(string what, int act, int exp, int tol);
    int d;
    vecs++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // one clock: update the model for the edge, then check away from it
  task automatic step();
    logic [31:0] sum;
    @(posedge clk);
    if (rst) begin
      accM = '0; expV1 = 0; expV2 = 0; heldSin = 0; heldCos = 0;
    end else begin
      expV2 = expV1; expP2 = expP1;
      if (expV2) begin
        heldSin = refWave(expP2, 0);
        heldCos = refWave(expP2, 1);
      end
      expV1 = en;
      if (en) begin
        sum   = accM + {pcw, 16'h0000};
        expP1 = sum[31:18];
        accM  = accM + {1'b0, fcw};
      end
    end
    @(negedge clk);
    chk("valid", int'(outValid), int'(expV2), 0);
    chk("sin", int'(sinOut), heldSin, 2);
    chk("cos", int'(cosOut), heldCos, 2);
  endtask

  task automatic doReset();
    en = 0; rst = 1;
    step(); step();
    rst = 0;
  endtask

  task automatic tReset();
    curReq = "R1";
    doReset();
    chk("valid after reset", int'(outValid), 0, 0);
    chk("sin after reset", int'(sinOut), 0, 0);
    chk("cos after reset", int'(cosOut), 0, 0);
    fcw = 31'h0123_4567; pcw = '0; en = 1;
    step(); en = 0; step();
    // R1: first sample phase is zero -> sin 0, cos full scale
    chk("first sin", int'(sinOut), 0, 0);
    chk("first cos", int'(cosOut), 32767, 0);
  endtask

  task automatic tQuadrants();
    int expS[4] = '{0, 32767, 0, -32767};
    int expC[4] = '{32767, 0, -32767, 0};
    doReset();
    fcw = '0; en = 1;
    for (int q = 0; q < 4; q++) begin
      curReq = "R5";
      pcw = 16'(q * 16'h4000);
      step(); step(); step();
      curReq = "R7";
      chk("quadrant sin", int'(sinOut), expS[q], 0);
      curReq = "R8";
      chk("quadrant cos", int'(cosOut), expC[q], 0);
    end
    en = 0; step(); step();
  endtask

  task automatic tSweep();
    curReq = "R2";
    doReset();
    fcw = 31'h0123_4567; pcw = 16'h1357; en = 1;
    for (int k = 0; k < 40; k++) step();
    curReq = "R9";
    fcw = 31'h0034_0000; pcw = 16'h0000;
    for (int k = 0; k < 20; k++) step();
    en = 0; step(); step();
  endtask

  task automatic tGaps();
    int s0, c0;
    curReq = "R3";
    doReset();
    fcw = 31'h0555_1234; pcw = 16'h2000;
    for (int k = 0; k < 30; k++) begin
      en = (k % 3 != 0);
      step();
    end
    en = 0; step(); step();
    s0 = int'(sinOut); c0 = int'(cosOut);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("held sin", int'(sinOut), s0, 0);
      chk("held cos", int'(cosOut), c0, 0);
    end
  endtask

  task automatic tWrap();
    curReq = "R4";
    doReset();
    fcw = 31'h7FFF_FFFF; pcw = 16'h0100; en = 1;
    for (int k = 0; k < 20; k++) step();
    fcw = 31'h1F00_0001;
    for (int k = 0; k < 30; k++) step();
    en = 0; step(); step();
  endtask

  task automatic tTrunc();
    int s0;
    curReq = "R6";
    doReset();
    fcw = 31'd1; pcw = 16'h0010; en = 1;
    step(); step();
    s0 = int'(sinOut);
    chk("trunc start", s0, refWave(14'd4, 0), 2);
    for (int k = 0; k < 12; k++) begin
      step();
      chk("trunc const sin", int'(sinOut), s0, 0);
    end
    en = 0; step(); step();
  endtask

  task automatic tSpurFree();
    int rec[48];
    int n = 0;
    curReq = "R10";
    doReset();
    fcw = 31'h1000_0000; pcw = 16'h0000; en = 1;
    for (int k = 0; k < 50; k++) begin
      step();
      if (outValid && n < 48) begin
        rec[n] = int'(sinOut);
        n++;
      end
    end
    for (int k = 0; k + 16 < n; k++) chk("periodic sin", rec[k + 16], rec[k], 0);
    en = 0; step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    step(); step();
    tReset();
    tQuadrants();
    tSweep();
    tGaps();
    tWrap();
    tTrunc();
    tSpurFree();
    finishRun();
  end

endmodule